// File: doc/BRIEF.md
# Serial Receive Character Queue

This block sits between a serial receiver's deserializer and the register interface of the channel. Each finished character arrives on a one-cycle write strobe together with three error marks (parity, framing, break). Up to sixteen such characters are queued in arrival order. The oldest character and its marks are always visible at the output, and a register read strobe removes it.

Around the queue the block produces the flags that the interrupt logic and the line status register need. A fill-level flag compares the occupancy with one of four selectable thresholds. A stale-data flag signals that characters have waited for four character times with no traffic. A sticky error summary reports any errored character taken in. A sticky overrun flag is also produced. A queue-mode input selects between the sixteen-deep queue and a single holding register with overwrite behaviour. A flush command empties the queue in one cycle.

Top module: `rx_char_fifo`

## Requirements
- R1: `rd_data` and the three `head_*` outputs present the oldest stored character. A `rd_strobe` on a non-empty queue removes it in the same clock, so characters leave in arrival order. `data_ready` is high exactly when `fill_count` is non-zero.
- R2: In queue mode (`fifo_en`=1) up to 16 characters are held, and `fill_count` reports the occupancy, which never exceeds 16.
- R3: `trig_hit` is high exactly when `fifo_en`=1 and `fill_count` is at least the selected level. The levels for `trig_sel` are 2'b00 for 1, 2'b01 for 4, 2'b10 for 8 and 2'b11 for 14.
- R4: In queue mode with a non-empty queue, `tmo_flag` rises in the cycle after the fourth `char_tick` pulse counted since the last accepted write, removal or flush. Any accepted write or removal clears it at the next edge.
- R5: In queue mode, a write while 16 characters are held and no removal happens in the same cycle is discarded. The count and the head stay unchanged, and `overrun` is set. A write together with a removal while full is accepted.
- R6: `overrun` stays set until an `lsr_rd` pulse, which clears it unless a new overrun happens in the same cycle.
- R7: `err_sum` sets in the cycle after a character with any error mark is accepted, and then stays set. An `lsr_rd` pulse clears it unless errored characters remain queued after that cycle.
- R8: A `fifo_clr` pulse empties the queue at the next edge and discards a write in the same cycle. It leaves `overrun` and `err_sum` unchanged.
- R9: With `fifo_en`=0 the block holds one character. A new write while it is occupied replaces it and sets `overrun`. `trig_hit` and `tmo_flag` stay low in this mode.
- R10: Any change of `fifo_en` empties the queue one cycle after the change is seen.
- R11: The error mark inputs map to `head_par_err` (parity), `head_frame_err` (framing) and `head_brk` (break) of the same character when it reaches the head.
- R12: `rd_strobe` on an empty queue has no effect.
- R13: After reset `fill_count` is 0 and `trig_hit`, `tmo_flag`, `err_sum` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 selects the 16-deep queue, 0 selects a single holding register |
| fifo_clr | input | 1 | Flush pulse |
| trig_sel | input | 2 | Fill-level threshold select |
| wr_valid | input | 1 | Received character strobe |
| wr_data | input | 8 | Received character |
| wr_par_err | input | 1 | Parity error mark of the character |
| wr_frame_err | input | 1 | Framing error mark of the character |
| wr_brk | input | 1 | Break mark of the character |
| rd_strobe | input | 1 | Data register read, removes the head |
| lsr_rd | input | 1 | Line status read, clears sticky flags |
| char_tick | input | 1 | One pulse per character time |
| rd_data | output | 8 | Head character |
| head_par_err | output | 1 | Parity mark of the head |
| head_frame_err | output | 1 | Framing mark of the head |
| head_brk | output | 1 | Break mark of the head |
| data_ready | output | 1 | Queue not empty |
| fill_count | output | 5 | Occupancy |
| trig_hit | output | 1 | Occupancy at or above threshold |
| tmo_flag | output | 1 | Stale-data timeout |
| err_sum | output | 1 | Sticky errored-character summary |
| overrun | output | 1 | Sticky overrun |

## Verification
The bench builds the block with its defaults, a depth of 16 and a four-character timeout. At these values the full queue, the highest threshold of 14 and the timeout can all be reached in a few dozen cycles. This lets every path be exercised: overrun with and without a simultaneous read, the 13/14 boundary of the top threshold, and the fourth tick of the timeout. The single-register mode and the flush on a mode change are exercised at the same defaults.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rx_word_t;

    // Threshold in characters for the two-bit select.
    function automatic int unsigned trig_bytes(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic word_has_err(input rx_word_t w);
        return w.brk | w.frm | w.par;
    endfunction

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
    import rx_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          cap_one,
    input  logic          push,
    input  rx_word_t      push_word,
    input  logic          pop_req,
    output rx_word_t      head_word,
    output logic [CW-1:0] count,
    output logic          acc_push,
    output logic          do_pop,
    output logic          overwrite,
    output logic          ovr_evt
);
    localparam int AW = $clog2(DEPTH);

    rx_word_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   limit;
    logic            empty, at_limit;

    always_comb begin
        empty     = (count == '0);
        limit     = cap_one ? CW'(1) : CW'(DEPTH);
        at_limit  = (count >= limit);
        do_pop    = pop_req & ~empty & ~clr;
        acc_push  = push & ~clr & (~at_limit | do_pop);
        ovr_evt   = push & ~clr & at_limit & ~do_pop;
        overwrite = ovr_evt & cap_one;
        head_word = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (acc_push)       mem[wr_ptr] <= push_word;
        else if (overwrite) mem[rd_ptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (acc_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)   rd_ptr <= rd_ptr + AW'(1);
            count <= count + CW'(acc_push) - CW'(do_pop);
        end
    end

    // R2: occupancy never exceeds the depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R5: a dropped write leaves the queue untouched
    a_r5_full_drop: assert property (@(posedge clk) disable iff (rst)
        (ovr_evt && !cap_one) |=> (count == $past(count)) && (head_word == $past(head_word)));

    // R8: flush empties at the next edge
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

endmodule

// File: rtl/rx_fifo_timer.sv
module rx_fifo_timer #(
    parameter int TMO_CHARS = 4,
    parameter int TW        = $clog2(TMO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic restart,
    input  logic tick,
    output logic tmo_flag
);
    logic [TW-1:0] cnt;
    logic          at_end;

    assign at_end   = (cnt == TW'(TMO_CHARS));
    assign tmo_flag = active & at_end;

    always_ff @(posedge clk) begin
        if (rst || restart || !active) cnt <= '0;
        else if (tick && !at_end)      cnt <= cnt + TW'(1);
    end

    // R4: the flag can only appear on a counted character time
    a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_flag) |-> $past(tick));

    // R4: traffic clears the flag
    a_r4_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tmo_flag);

endmodule

// File: rtl/rx_fifo_flags.sv
module rx_fifo_flags #(
    parameter int CW = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    input  logic ovr_evt,
    input  logic lsr_rd,
    output logic err_sum,
    output logic overrun
);
    logic [CW-1:0] err_cnt, err_cnt_nxt;

    always_comb begin
        if (clr) err_cnt_nxt = '0;
        else     err_cnt_nxt = err_cnt + CW'(inc) - CW'(dec);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_cnt <= '0;
            err_sum <= 1'b0;
            overrun <= 1'b0;
        end else begin
            err_cnt <= err_cnt_nxt;
            err_sum <= lsr_rd ? (err_cnt_nxt != '0) : (err_sum | inc);
            overrun <= ovr_evt | (overrun & ~lsr_rd);
        end
    end

    // R6: a status read clears the sticky overrun
    a_r6_lsr_clears: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !ovr_evt) |=> !overrun);

    // R6: overrun is set by the event
    a_r6_ovr_sets: assert property (@(posedge clk) disable iff (rst)
        ovr_evt |=> overrun);

    // R7: an accepted errored character sets the summary
    a_r7_sum_sets: assert property (@(posedge clk) disable iff (rst)
        inc |=> err_sum);

endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
    import rx_fifo_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int TMO_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_en,
    input  logic       fifo_clr,
    input  logic [1:0] trig_sel,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       wr_par_err,
    input  logic       wr_frame_err,
    input  logic       wr_brk,
    input  logic       rd_strobe,
    input  logic       lsr_rd,
    input  logic       char_tick,
    output logic [7:0] rd_data,
    output logic       head_par_err,
    output logic       head_frame_err,
    output logic       head_brk,
    output logic       data_ready,
    output logic [4:0] fill_count,
    output logic       trig_hit,
    output logic       tmo_flag,
    output logic       err_sum,
    output logic       overrun
);
    localparam int CW = $clog2(DEPTH + 1);

    rx_word_t      in_word, head_word;
    logic [CW-1:0] count, trig_lvl;
    logic          en_q, flush, acc_push, do_pop, overwrite, ovr_evt;
    logic          err_inc, err_dec, restart, tmo_raw;

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= fifo_en;
    end

    always_comb begin
        in_word = '{brk: wr_brk, frm: wr_frame_err, par: wr_par_err, data: wr_data};
        flush   = fifo_clr | (fifo_en != en_q);
        err_inc = (acc_push | overwrite) & word_has_err(in_word);
        err_dec = (do_pop | overwrite) & word_has_err(head_word);
        restart = acc_push | overwrite | do_pop | flush;
        trig_lvl = CW'(trig_bytes(trig_sel));
    end

    rx_fifo_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (flush),
        .cap_one   (~fifo_en),
        .push      (wr_valid),
        .push_word (in_word),
        .pop_req   (rd_strobe),
        .head_word (head_word),
        .count     (count),
        .acc_push  (acc_push),
        .do_pop    (do_pop),
        .overwrite (overwrite),
        .ovr_evt   (ovr_evt)
    );

    rx_fifo_timer #(.TMO_CHARS(TMO_CHARS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .active   (fifo_en & (count != '0)),
        .restart  (restart),
        .tick     (char_tick),
        .tmo_flag (tmo_raw)
    );

    rx_fifo_flags #(.CW(CW)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr     (flush),
        .inc     (err_inc),
        .dec     (err_dec),
        .ovr_evt (ovr_evt),
        .lsr_rd  (lsr_rd),
        .err_sum (err_sum),
        .overrun (overrun)
    );

    assign rd_data        = head_word.data;
    assign head_par_err   = head_word.par;
    assign head_frame_err = head_word.frm;
    assign head_brk       = head_word.brk;
    assign data_ready     = (count != '0);
    assign fill_count     = 5'(count);
    assign trig_hit       = fifo_en & (count >= trig_lvl);
    assign tmo_flag       = tmo_raw;

    // R9: the single-register mode raises neither level nor timeout flag
    a_r9_legacy_quiet: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> !tmo_flag);

    // R10: a mode change empties the queue
    a_r10_mode_flush: assert property (@(posedge clk) disable iff (rst)
        (fifo_en != en_q) |=> (count == '0));

endmodule

// File: tb/rx_char_fifo_bench.sv
module rx_char_fifo_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b1, fifo_clr = 1'b0;
    logic [1:0] trig_sel = 2'b01;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_par_err = 1'b0, wr_frame_err = 1'b0, wr_brk = 1'b0;
    logic       rd_strobe = 1'b0, lsr_rd = 1'b0, char_tick = 1'b0;
    logic [7:0] rd_data;
    logic       head_par_err, head_frame_err, head_brk, data_ready;
    logic [4:0] fill_count;
    logic       trig_hit, tmo_flag, err_sum, overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_char_fifo u_rx_char_fifo (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
        .trig_sel(trig_sel), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_par_err(wr_par_err), .wr_frame_err(wr_frame_err), .wr_brk(wr_brk),
        .rd_strobe(rd_strobe), .lsr_rd(lsr_rd), .char_tick(char_tick),
        .rd_data(rd_data), .head_par_err(head_par_err),
        .head_frame_err(head_frame_err), .head_brk(head_brk),
        .data_ready(data_ready), .fill_count(fill_count), .trig_hit(trig_hit),
        .tmo_flag(tmo_flag), .err_sum(err_sum), .overrun(overrun)
    );

    typedef struct packed {
        logic [1:0] tsel;
        logic       clr;
        logic       wr;
        logic [7:0] d;
        logic [2:0] e;
        logic       rd;
        logic       lsr;
        logic       tick;
        logic [4:0] cnt;
        logic [7:0] head;
        logic       trig;
        logic       tmo;
        logic       ovr;
        logic       esum;
    } vec_t;

    localparam int NV = 18;
    // e = {break, framing, parity}
    localparam vec_t VECS [NV] = '{
        '{2'b01,1'b0,1'b1,8'hA1,3'b000,1'b0,1'b0,1'b0, 5'd1,8'hA1,1'b0,1'b0,1'b0,1'b0},
        '{2'b01,1'b0,1'b1,8'hB2,3'b001,1'b0,1'b0,1'b0, 5'd2,8'hA1,1'b0,1'b0,1'b0,1'b1},
        '{2'b01,1'b0,1'b1,8'hC3,3'b000,1'b0,1'b0,1'b0, 5'd3,8'hA1,1'b0,1'b0,1'b0,1'b1},
        '{2'b01,1'b0,1'b1,8'hD4,3'b000,1'b0,1'b0,1'b0, 5'd4,8'hA1,1'b1,1'b0,1'b0,1'b1},
        '{2'b01,1'b0,1'b0,8'h00,3'b000,1'b1,1'b0,1'b0, 5'd3,8'hB2,1'b0,1'b0,1'b0,1'b1},
        '{2'b01,1'b0,1'b0,8'h00,3'b000,1'b0,1'b1,1'b0, 5'd3,8'hB2,1'b0,1'b0,1'b0,1'b1},
        '{2'b01,1'b0,1'b0,8'h00,3'b000,1'b1,1'b0,1'b0, 5'd2,8'hC3,1'b0,1'b0,1'b0,1'b1},
        '{2'b01,1'b0,1'b0,8'h00,3'b000,1'b0,1'b1,1'b0, 5'd2,8'hC3,1'b0,1'b0,1'b0,1'b0},
        '{2'b01,1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,1'b1, 5'd2,8'hC3,1'b0,1'b0,1'b0,1'b0},
        '{2'b01,1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,1'b1, 5'd2,8'hC3,1'b0,1'b0,1'b0,1'b0},
        '{2'b01,1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,1'b1, 5'd2,8'hC3,1'b0,1'b0,1'b0,1'b0},
        '{2'b01,1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,1'b1, 5'd2,8'hC3,1'b0,1'b1,1'b0,1'b0},
        '{2'b01,1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,1'b0, 5'd2,8'hC3,1'b0,1'b1,1'b0,1'b0},
        '{2'b01,1'b0,1'b0,8'h00,3'b000,1'b1,1'b0,1'b0, 5'd1,8'hD4,1'b0,1'b0,1'b0,1'b0},
        '{2'b01,1'b0,1'b0,8'h00,3'b000,1'b1,1'b0,1'b0, 5'd0,8'h00,1'b0,1'b0,1'b0,1'b0},
        '{2'b01,1'b0,1'b0,8'h00,3'b000,1'b1,1'b0,1'b0, 5'd0,8'h00,1'b0,1'b0,1'b0,1'b0},
        '{2'b00,1'b0,1'b1,8'hE5,3'b000,1'b0,1'b0,1'b0, 5'd1,8'hE5,1'b1,1'b0,1'b0,1'b0},
        '{2'b00,1'b1,1'b1,8'h66,3'b000,1'b0,1'b0,1'b0, 5'd0,8'h00,1'b0,1'b0,1'b0,1'b0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, wait past the edge, release the pulses.
    task automatic op(input logic wr, input logic [7:0] d, input logic [2:0] e,
                      input logic rd, input logic lsr, input logic tick, input logic clr);
        wr_valid = wr; wr_data = d;
        wr_brk = e[2]; wr_frame_err = e[1]; wr_par_err = e[0];
        rd_strobe = rd; lsr_rd = lsr; char_tick = tick; fifo_clr = clr;
        @(posedge clk); #5;
        wr_valid = 1'b0; rd_strobe = 1'b0; lsr_rd = 1'b0; char_tick = 1'b0; fifo_clr = 1'b0;
        wr_brk = 1'b0; wr_frame_err = 1'b0; wr_par_err = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #5 rst = 1'b0;
        op(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);

        // R13: reset state
        chk("R13 count", 16'(fill_count), 16'd0);
        chk("R13 trig", 16'(trig_hit), 16'd0);
        chk("R13 tmo", 16'(tmo_flag), 16'd0);
        chk("R13 err_sum", 16'(err_sum), 16'd0);
        chk("R13 overrun", 16'(overrun), 16'd0);

        // Table: order (R1), thresholds (R3), timeout (R4), summary (R7),
        // empty read (R12, vector 15), flush (R8, vector 17)
        for (int i = 0; i < NV; i++) begin
            trig_sel = VECS[i].tsel;
            op(VECS[i].wr, VECS[i].d, VECS[i].e, VECS[i].rd, VECS[i].lsr,
               VECS[i].tick, VECS[i].clr);
            chk("R1 count", 16'(fill_count), 16'(VECS[i].cnt));
            chk("R1 ready", 16'(data_ready), 16'(VECS[i].cnt != 5'd0));
            if (VECS[i].cnt != 5'd0) chk("R1 head", 16'(rd_data), 16'(VECS[i].head));
            chk("R3 trig", 16'(trig_hit), 16'(VECS[i].trig));
            chk("R4 timeout", 16'(tmo_flag), 16'(VECS[i].tmo));
            chk("R6 overrun", 16'(overrun), 16'(VECS[i].ovr));
            chk("R7 err_sum", 16'(err_sum), 16'(VECS[i].esum));
        end

        // R2 / R3: fill to 16 with threshold 14
        trig_sel = 2'b11;
        for (int i = 0; i < 16; i++) begin
            op(1'b1, 8'(8'h10 + i), 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
            if (i == 12) chk("R3 below 14", 16'(trig_hit), 16'd0);
            if (i == 13) chk("R3 at 14", 16'(trig_hit), 16'd1);
        end
        chk("R2 full count", 16'(fill_count), 16'd16);

        // R5: write while full is dropped
        op(1'b1, 8'hEE, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 count kept", 16'(fill_count), 16'd16);
        chk("R5 head kept", 16'(rd_data), 16'h10);
        chk("R5 overrun", 16'(overrun), 16'd1);

        // R5: write with read while full is accepted
        op(1'b1, 8'hEF, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 push+pop count", 16'(fill_count), 16'd16);
        chk("R5 push+pop head", 16'(rd_data), 16'h11);

        // R6: status read clears overrun
        op(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R6 lsr clears", 16'(overrun), 16'd0);

        // R1: drain in order
        for (int i = 0; i < 16; i++) begin
            chk("R1 drain order", 16'(rd_data), (i < 15) ? 16'(8'h11 + i) : 16'h00EF);
            op(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
        end
        chk("R1 drained", 16'(fill_count), 16'd0);

        // R11: error marks travel with the character (frame + break)
        op(1'b1, 8'h5A, 3'b110, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11 par", 16'(head_par_err), 16'd0);
        chk("R11 frame", 16'(head_frame_err), 16'd1);
        chk("R11 brk", 16'(head_brk), 16'd1);
        chk("R7 err_sum set", 16'(err_sum), 16'd1);

        // R8: flush keeps sticky flags
        op(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R8 flushed", 16'(fill_count), 16'd0);
        chk("R8 err_sum kept", 16'(err_sum), 16'd1);
        op(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R7 err_sum cleared", 16'(err_sum), 16'd0);

        // R10: mode change empties the queue
        op(1'b1, 8'h01, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
        op(1'b1, 8'h02, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10 before", 16'(fill_count), 16'd2);
        fifo_en = 1'b0;
        op(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10 flushed", 16'(fill_count), 16'd0);

        // R9: single holding register with overwrite
        op(1'b1, 8'h11, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 one held", 16'(fill_count), 16'd1);
        chk("R9 trig low", 16'(trig_hit), 16'd0);
        op(1'b1, 8'h22, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 count", 16'(fill_count), 16'd1);
        chk("R9 replaced", 16'(rd_data), 16'h22);
        chk("R9 overrun", 16'(overrun), 16'd1);
        for (int i = 0; i < 5; i++) op(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R9 no timeout", 16'(tmo_flag), 16'd0);

        // R12: empty read leaves the state alone
        op(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R12 popped", 16'(fill_count), 16'd0);
        op(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R12 empty read", 16'(fill_count), 16'd0);

        finish_run();
    end

endmodule